// File: doc/BRIEF.md
# String Port Transfer Sequencer

This block carries out a single element of a string transfer between an I/O port and memory. A start request names the transfer direction: port-to-memory (input string) or memory-to-port (output string). It also carries the element form, the operand size, the address size, the direction flag, the two index registers, the port register and an optional segment override. The current privilege state comes with the same request.

From these the sequencer decides whether a port permission query is needed. It then runs the memory and port accesses in a fixed order over valid/ready style interfaces, waiting at each step for the response. It finishes with a one-cycle `done` pulse. On success the pulse carries the stepped index register. On a fault it carries a fault kind and error code, and both index registers keep their original values.

Repeat loops, segment translation, paging and the permission bitmap lookup are left to the surrounding logic. The block only issues the requests and consumes the answers.

Top module: `strio_seq`

## Requirements
- R1: A permission query (`perm_req`) is issued only when `prot_en` is 1 and either `v86` is 1 or `cpl` is numerically greater than `iopl`. Otherwise the transfer goes straight to its first memory access.
- R2: The query carries the port number and the access width in bytes. A denial (`perm_ok`=0) ends the operation with `fault_kind`=1 (general protection) and `err_code`=0, and no memory or port request follows.
- R3: In port-to-memory mode (`dir_ins`=1), three accesses happen in order. First a memory write of zero at the destination, then a port read, then a memory write of the port value (masked to the element width) at the same address.
- R4: Segment codes are ES=0 and DS=3. Port-to-memory always uses ES, whatever the override. Memory-to-port uses `seg_ovr` when `seg_ovr_vld` is 1, else DS.
- R5: The element size is 1 byte when `byte_form` is 1. Otherwise it is 4 bytes when `op32` is 1 and 2 bytes when `op32` is 0. `mem_size`, `perm_size` and `io_size` give that size in bytes.
- R6: On success the index in use (the destination index for port-to-memory, the source index for memory-to-port) decreases by the element size when `dflag` is 1 and increases otherwise. The other index is returned unchanged.
- R7: With `addr32`=1 the full 32-bit index forms the address and is stepped. With `addr32`=0 the address is the low 16 bits, zero-extended. Only the low 16 bits are stepped, wrapping modulo 65536, and the upper 16 bits are kept.
- R8: A memory fault response ends the operation with `fault_kind`=2 and `err_code` equal to `mem_ferr`. Both indices stay unchanged. A fault on the zero-write probe prevents any port read.
- R9: Each accepted start produces exactly one `done` pulse, one cycle long, with `new_di`/`new_si` valid in that cycle. `fault_kind` is 0 on success.
- R10: Only one of `perm_req`, `mem_req`, `io_req` is high at a time. Each request and its attributes are held until the matching ack arrives.
- R11: The port number is always the low 16 bits of `dx_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start one element transfer (taken when idle) |
| dir_ins | input | 1 | 1 = port-to-memory, 0 = memory-to-port |
| byte_form | input | 1 | Byte element form |
| op32 | input | 1 | 32-bit operand size for the word form |
| addr32 | input | 1 | 32-bit address size |
| dflag | input | 1 | Direction flag, 1 = decrement |
| di_in | input | 32 | Destination index |
| si_in | input | 32 | Source index |
| dx_in | input | 32 | Port register (low 16 bits used) |
| seg_ovr_vld | input | 1 | Segment override present |
| seg_ovr | input | 3 | Override segment code |
| prot_en | input | 1 | Protection enabled |
| v86 | input | 1 | Virtual-8086 mode |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| perm_req | output | 1 | Permission query valid |
| perm_port | output | 16 | Queried port |
| perm_size | output | 3 | Queried width in bytes |
| perm_ack | input | 1 | Query answer valid |
| perm_ok | input | 1 | Access allowed |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write |
| mem_seg | output | 3 | Segment code |
| mem_addr | output | 32 | Offset |
| mem_size | output | 3 | Access width in bytes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory response valid |
| mem_fault | input | 1 | Memory response is a fault |
| mem_ferr | input | 16 | Error code of a memory fault |
| mem_rdata | input | 32 | Read data |
| io_req | output | 1 | Port request valid |
| io_we | output | 1 | Port write |
| io_port | output | 16 | Port number |
| io_size | output | 3 | Port width in bytes |
| io_wdata | output | 32 | Port write data |
| io_ack | input | 1 | Port response valid |
| io_rdata | input | 32 | Port read data |
| done | output | 1 | One-cycle completion pulse |
| fault_kind | output | 2 | 0 none, 1 general protection, 2 memory |
| err_code | output | 16 | Fault error code |
| new_di | output | 32 | Resulting destination index |
| new_si | output | 32 | Resulting source index |

## Verification
The hardest case to reach is a fault on the second destination write. The port read has already been consumed by then, yet the index must still come back unchanged. The bench reaches it with a memory responder that counts accesses and answers exactly the second one with a fault, then checks that one port read was logged and that the index held. The same responder adds response latency, so every request is held across several cycles before its ack. It also decides the permission answer, which steers the denial path.

// File: rtl/strio_pkg.sv
package strio_pkg;
  localparam int XW  = 32;  // index / data width
  localparam int PW  = 16;  // port number width
  localparam int SW  = 3;   // segment code width
  localparam int NBW = 3;   // byte-count width
  localparam int EW  = 16;  // error code width

  localparam logic [SW-1:0] SEG_ES = 3'd0;
  localparam logic [SW-1:0] SEG_DS = 3'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PERM, ST_PROBE, ST_PIN, ST_STORE, ST_LOAD, ST_POUT, ST_FIN
  } st_e;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0, FK_GP = 2'd1, FK_MEM = 2'd2
  } fkind_e;

  function automatic logic [NBW-1:0] elem_bytes(input logic byte_form, input logic op32);
    if (byte_form) return 3'd1;
    return op32 ? 3'd4 : 3'd2;
  endfunction

  function automatic logic [XW-1:0] width_mask(input logic [NBW-1:0] nb);
    case (nb)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [XW-1:0] next_index(input logic [XW-1:0] idx, input logic [NBW-1:0] nb,
                                               input logic df, input logic a32);
    logic [XW-1:0] delta;
    logic [XW-1:0] full;
    logic [15:0]   low;
    delta = {{(XW-NBW){1'b0}}, nb};
    full  = df ? idx - delta : idx + delta;
    low   = df ? idx[15:0] - delta[15:0] : idx[15:0] + delta[15:0];
    return a32 ? full : {idx[XW-1:16], low};
  endfunction

  function automatic logic [XW-1:0] eff_addr(input logic [XW-1:0] idx, input logic a32);
    return a32 ? idx : {{(XW-16){1'b0}}, idx[15:0]};
  endfunction
endpackage

// File: rtl/strio_priv_gate.sv
module strio_priv_gate #(
  parameter int LW = 2
) (
  input  logic          prot_en,
  input  logic          v86,
  input  logic [LW-1:0] cpl,
  input  logic [LW-1:0] iopl,
  output logic          need_chk
);
  assign need_chk = prot_en && (v86 || (cpl > iopl));
endmodule

// File: rtl/strio_index_step.sv
module strio_index_step
  import strio_pkg::*;
(
  input  logic [XW-1:0]  idx,
  input  logic [NBW-1:0] nb,
  input  logic           df,
  input  logic           a32,
  output logic [XW-1:0]  idx_nxt,
  output logic [XW-1:0]  addr
);
  assign idx_nxt = next_index(idx, nb, df, a32);
  assign addr    = eff_addr(idx, a32);
endmodule

// File: rtl/strio_seq.sv
module strio_seq
  import strio_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           dir_ins,
  input  logic           byte_form,
  input  logic           op32,
  input  logic           addr32,
  input  logic           dflag,
  input  logic [31:0]    di_in,
  input  logic [31:0]    si_in,
  input  logic [31:0]    dx_in,
  input  logic           seg_ovr_vld,
  input  logic [2:0]     seg_ovr,
  input  logic           prot_en,
  input  logic           v86,
  input  logic [1:0]     cpl,
  input  logic [1:0]     iopl,
  output logic           perm_req,
  output logic [15:0]    perm_port,
  output logic [2:0]     perm_size,
  input  logic           perm_ack,
  input  logic           perm_ok,
  output logic           mem_req,
  output logic           mem_we,
  output logic [2:0]     mem_seg,
  output logic [31:0]    mem_addr,
  output logic [2:0]     mem_size,
  output logic [31:0]    mem_wdata,
  input  logic           mem_ack,
  input  logic           mem_fault,
  input  logic [15:0]    mem_ferr,
  input  logic [31:0]    mem_rdata,
  output logic           io_req,
  output logic           io_we,
  output logic [15:0]    io_port,
  output logic [2:0]     io_size,
  output logic [31:0]    io_wdata,
  input  logic           io_ack,
  input  logic [31:0]    io_rdata,
  output logic           done,
  output logic [1:0]     fault_kind,
  output logic [15:0]    err_code,
  output logic [31:0]    new_di,
  output logic [31:0]    new_si
);
  st_e            state;
  logic           ins_q, a32_q, df_q, probed_q;
  logic [NBW-1:0] nb_q;
  logic [SW-1:0]  seg_q;
  logic [PW-1:0]  port_q;
  logic [XW-1:0]  di_q, si_q, data_q;
  fkind_e         fk_q;
  logic [EW-1:0]  ec_q;

  // named internal events
  logic           need_chk;
  logic           accept;
  logic [XW-1:0]  idx_sel, idx_nxt, addr_cur;

  assign accept  = (state == ST_IDLE) && start;
  assign idx_sel = ins_q ? di_q : si_q;

  strio_priv_gate #(.LW(2)) u_priv (
    .prot_en (prot_en),
    .v86     (v86),
    .cpl     (cpl),
    .iopl    (iopl),
    .need_chk(need_chk)
  );

  strio_index_step u_step (
    .idx    (idx_sel),
    .nb     (nb_q),
    .df     (df_q),
    .a32    (a32_q),
    .idx_nxt(idx_nxt),
    .addr   (addr_cur)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ins_q    <= 1'b0;
      a32_q    <= 1'b0;
      df_q     <= 1'b0;
      probed_q <= 1'b0;
      nb_q     <= 3'd1;
      seg_q    <= SEG_ES;
      port_q   <= '0;
      di_q     <= '0;
      si_q     <= '0;
      data_q   <= '0;
      fk_q     <= FK_NONE;
      ec_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          ins_q    <= dir_ins;
          a32_q    <= addr32;
          df_q     <= dflag;
          nb_q     <= elem_bytes(byte_form, op32);
          seg_q    <= dir_ins ? SEG_ES : (seg_ovr_vld ? seg_ovr : SEG_DS);
          port_q   <= dx_in[PW-1:0];
          di_q     <= di_in;
          si_q     <= si_in;
          probed_q <= 1'b0;
          fk_q     <= FK_NONE;
          ec_q     <= '0;
          if (need_chk)     state <= ST_PERM;
          else if (dir_ins) state <= ST_PROBE;
          else              state <= ST_LOAD;
        end
        ST_PERM: if (perm_ack) begin
          if (!perm_ok) begin
            fk_q  <= FK_GP;
            ec_q  <= '0;
            state <= ST_FIN;
          end else begin
            state <= ins_q ? ST_PROBE : ST_LOAD;
          end
        end
        ST_PROBE: if (mem_ack) begin
          if (mem_fault) begin
            fk_q  <= FK_MEM;
            ec_q  <= mem_ferr;
            state <= ST_FIN;
          end else begin
            probed_q <= 1'b1;
            state    <= ST_PIN;
          end
        end
        ST_PIN: if (io_ack) begin
          data_q <= io_rdata & width_mask(nb_q);
          state  <= ST_STORE;
        end
        ST_STORE: if (mem_ack) begin
          if (mem_fault) begin
            fk_q <= FK_MEM;
            ec_q <= mem_ferr;
          end else begin
            di_q <= idx_nxt;
          end
          state <= ST_FIN;
        end
        ST_LOAD: if (mem_ack) begin
          if (mem_fault) begin
            fk_q  <= FK_MEM;
            ec_q  <= mem_ferr;
            state <= ST_FIN;
          end else begin
            data_q <= mem_rdata & width_mask(nb_q);
            state  <= ST_POUT;
          end
        end
        ST_POUT: if (io_ack) begin
          si_q  <= idx_nxt;
          state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign perm_req  = (state == ST_PERM);
  assign perm_port = port_q;
  assign perm_size = nb_q;

  assign mem_req   = (state == ST_PROBE) || (state == ST_STORE) || (state == ST_LOAD);
  assign mem_we    = (state != ST_LOAD);
  assign mem_seg   = seg_q;
  assign mem_addr  = addr_cur;
  assign mem_size  = nb_q;
  assign mem_wdata = (state == ST_STORE) ? data_q : '0;

  assign io_req    = (state == ST_PIN) || (state == ST_POUT);
  assign io_we     = (state == ST_POUT);
  assign io_port   = port_q;
  assign io_size   = nb_q;
  assign io_wdata  = data_q;

  assign done       = (state == ST_FIN);
  assign fault_kind = fk_q;
  assign err_code   = ec_q;
  assign new_di     = di_q;
  assign new_si     = si_q;

  // R1: no query when the privilege gate says none is needed
  assert_query_rule_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !need_chk) |=> !perm_req);

  // R2: a denial ends the operation with a GP fault
  assert_gp_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_req && perm_ack && !perm_ok) |=> (done && fault_kind == FK_GP && !mem_req && !io_req));

  // R3: the port is read only after a successful probe
  assert_port_after_probe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && !io_we) |-> probed_q);

  // R4: port-to-memory traffic always targets ES
  assert_ins_es_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && ins_q) |-> (mem_seg == SEG_ES));

  // R9: done is a single-cycle pulse
  assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: a pending memory request holds its attributes
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R10: requests are mutually exclusive
  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({perm_req, mem_req, io_req}));
endmodule

// File: tb/strio_seq_test.sv
module strio_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, dir_ins = 0, byte_form = 0, op32 = 0, addr32 = 0, dflag = 0;
  logic [31:0] di_in = 0, si_in = 0, dx_in = 0;
  logic seg_ovr_vld = 0; logic [2:0] seg_ovr = 0;
  logic prot_en = 0, v86 = 0; logic [1:0] cpl = 0, iopl = 0;
  logic perm_req; logic [15:0] perm_port; logic [2:0] perm_size;
  logic perm_ack = 0, perm_ok = 0;
  logic mem_req, mem_we; logic [2:0] mem_seg, mem_size; logic [31:0] mem_addr, mem_wdata;
  logic mem_ack = 0, mem_fault = 0; logic [15:0] mem_ferr = 0; logic [31:0] mem_rdata = 0;
  logic io_req, io_we; logic [15:0] io_port; logic [2:0] io_size; logic [31:0] io_wdata;
  logic io_ack = 0; logic [31:0] io_rdata = 0;
  logic done; logic [1:0] fault_kind; logic [15:0] err_code; logic [31:0] new_di, new_si;

  always #(CLK_PERIOD/2) clk = ~clk;

  strio_seq uut (.*);

  int n_tests = 0, n_fail = 0;

  // responder configuration and logs
  int lat = 0, fault_at = 0, wait_cnt = 0, seq = 0;
  logic allow = 1'b1;
  logic [31:0] rd_mem = 32'h0, rd_io = 32'h0;
  int n_perm = 0, n_mem = 0, n_io = 0;
  logic [15:0] lp_port; logic [2:0] lp_size;
  logic        lm_we[4]; logic [2:0] lm_seg[4], lm_size[4]; logic [31:0] lm_addr[4], lm_wd[4];
  int          lm_seq[4];
  logic        li_we[4]; logic [15:0] li_port[4]; logic [2:0] li_size[4]; logic [31:0] li_wd[4];
  int          li_seq[4];

  initial forever begin
    @(negedge clk);
    perm_ack = 0; mem_ack = 0; mem_fault = 0; io_ack = 0;
    if (perm_req || mem_req || io_req) begin
      if (wait_cnt < lat) wait_cnt++;
      else begin
        wait_cnt = 0;
        seq++;
        if (perm_req) begin
          perm_ack = 1; perm_ok = allow; lp_port = perm_port; lp_size = perm_size; n_perm++;
        end
        if (mem_req && n_mem < 4) begin
          mem_ack = 1; mem_rdata = rd_mem; mem_ferr = 16'h00C7;
          mem_fault = (n_mem + 1 == fault_at);
          lm_we[n_mem] = mem_we; lm_seg[n_mem] = mem_seg; lm_size[n_mem] = mem_size;
          lm_addr[n_mem] = mem_addr; lm_wd[n_mem] = mem_wdata; lm_seq[n_mem] = seq; n_mem++;
        end
        if (io_req && n_io < 4) begin
          io_ack = 1; io_rdata = rd_io;
          li_we[n_io] = io_we; li_port[n_io] = io_port; li_size[n_io] = io_size;
          li_wd[n_io] = io_wdata; li_seq[n_io] = seq; n_io++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic prep(input int l, input int fa, input logic al);
    lat = l; fault_at = fa; allow = al; wait_cnt = 0;
    n_perm = 0; n_mem = 0; n_io = 0; seq = 0;
  endtask

  // start one op and wait for done; returns with outputs captured at the done negedge
  task automatic run_op(output bit got);
    int t;
    got = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (t = 0; t < 100; t++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic finish_pulse(input string tag);
    @(negedge clk);
    chk(done == 0, tag, {31'b0, done}, 0);
  endtask

  task automatic t_reset;
    chk(done == 0 && !perm_req && !mem_req && !io_req, "reset R9",
        {28'b0, done, perm_req, mem_req, io_req}, 0);
  endtask

  task automatic t_ins_byte_wrap;
    bit got;
    prep(0, 0, 1);
    dir_ins = 1; byte_form = 1; op32 = 1; addr32 = 0; dflag = 0;
    di_in = 32'h1234_FFFF; si_in = 32'h5555_0000; dx_in = 32'hABCD_0060;
    seg_ovr_vld = 1; seg_ovr = 3'd4; prot_en = 0; v86 = 1; cpl = 3; iopl = 0;
    rd_io = 32'hA5C3_5A7E;
    run_op(got);
    chk(got, "ins done R9", {31'b0, got}, 1);
    chk(fault_kind == 0, "ins no fault R9", {30'b0, fault_kind}, 0);
    chk(n_perm == 0, "no query pe=0 R1", n_perm, 0);
    chk(n_mem == 2 && n_io == 1, "ins access count R3", n_mem * 16 + n_io, 32'h21);
    chk(lm_we[0] && lm_wd[0] == 0 && lm_size[0] == 1, "probe write zero R3", lm_wd[0], 0);
    chk(lm_seq[0] < li_seq[0] && li_seq[0] < lm_seq[1] && !li_we[0], "ins order R3",
        li_seq[0], lm_seq[0] + 1);
    chk(lm_wd[1] == 32'h7E && lm_addr[1] == lm_addr[0], "store masked byte R3 R5", lm_wd[1], 32'h7E);
    chk(lm_seg[0] == 0 && lm_seg[1] == 0, "ES despite override R4", {29'b0, lm_seg[1]}, 0);
    chk(lm_addr[0] == 32'h0000_FFFF, "addr16 zero-extended R7", lm_addr[0], 32'h0000_FFFF);
    chk(li_port[0] == 16'h0060, "port from dx low R11", {16'b0, li_port[0]}, 32'h60);
    chk(new_di == 32'h1234_0000, "di wrap keeps upper R7 R6", new_di, 32'h1234_0000);
    chk(new_si == 32'h5555_0000, "si untouched R6", new_si, 32'h5555_0000);
    finish_pulse("ins single pulse R9");
  endtask

  task automatic t_outs_dword_ovr;
    bit got;
    prep(2, 0, 1);
    dir_ins = 0; byte_form = 0; op32 = 1; addr32 = 1; dflag = 1;
    di_in = 32'h0; si_in = 32'h0001_0100; dx_in = 32'h0000_03F8;
    seg_ovr_vld = 1; seg_ovr = 3'd4; prot_en = 1; v86 = 0; cpl = 3; iopl = 0;
    rd_mem = 32'hDEAD_BEEF;
    run_op(got);
    chk(got && fault_kind == 0, "outs done R9", {30'b0, fault_kind}, 0);
    chk(n_perm == 1 && lp_port == 16'h03F8 && lp_size == 4, "query port/size R2 R1",
        {lp_port, 13'b0, lp_size}, {16'h03F8, 16'h4});
    chk(n_mem == 1 && !lm_we[0] && lm_seg[0] == 4 && lm_addr[0] == 32'h0001_0100 && lm_size[0] == 4,
        "outs read via override R4 R7 R5", lm_addr[0], 32'h0001_0100);
    chk(n_io == 1 && li_we[0] && li_wd[0] == 32'hDEAD_BEEF && li_size[0] == 4,
        "port write data R10", li_wd[0], 32'hDEAD_BEEF);
    chk(new_si == 32'h0001_00FC, "si minus 4 R6", new_si, 32'h0001_00FC);
    finish_pulse("outs single pulse R9");
  endtask

  task automatic t_outs_word_ds;
    bit got;
    prep(1, 0, 1);
    dir_ins = 0; byte_form = 0; op32 = 0; addr32 = 0; dflag = 1;
    si_in = 32'hFFFF_0001; dx_in = 32'h0000_0070;
    seg_ovr_vld = 0; seg_ovr = 3'd5; prot_en = 1; v86 = 0; cpl = 0; iopl = 3;
    rd_mem = 32'h1234_5678;
    run_op(got);
    chk(n_perm == 0, "no query cpl<=iopl R1", n_perm, 0);
    chk(lm_seg[0] == 3 && lm_size[0] == 2, "default DS word R4 R5", {29'b0, lm_seg[0]}, 3);
    chk(li_wd[0] == 32'h5678, "word masked R5", li_wd[0], 32'h5678);
    chk(new_si == 32'hFFFF_FFFF, "si16 wraps down R7", new_si, 32'hFFFF_FFFF);
    finish_pulse("word single pulse R9");
  endtask

  task automatic t_gp_deny;
    bit got;
    prep(1, 0, 0);
    dir_ins = 1; byte_form = 0; op32 = 0; addr32 = 1; dflag = 0;
    di_in = 32'h0000_2000; si_in = 32'h0000_3000; dx_in = 32'h0000_0080;
    prot_en = 1; v86 = 1; cpl = 0; iopl = 3;
    run_op(got);
    chk(n_perm == 1 && lp_size == 2, "v86 forces query R1", n_perm, 1);
    chk(got && fault_kind == 1 && err_code == 0, "GP fault code 0 R2",
        {14'b0, fault_kind, err_code}, 32'h0001_0000);
    chk(n_mem == 0 && n_io == 0, "no access after deny R2", n_mem + n_io, 0);
    chk(new_di == 32'h2000 && new_si == 32'h3000, "indices kept on GP R2", new_di, 32'h2000);
    finish_pulse("gp single pulse R9");
  endtask

  task automatic t_probe_fault;
    bit got;
    prep(0, 1, 1);
    dir_ins = 1; byte_form = 0; op32 = 1; addr32 = 1; dflag = 0;
    di_in = 32'h0000_4000; prot_en = 0;
    run_op(got);
    chk(got && fault_kind == 2 && err_code == 16'h00C7, "probe fault code R8",
        {14'b0, fault_kind, err_code}, 32'h0002_00C7);
    chk(n_io == 0, "no port read after probe fault R8", n_io, 0);
    chk(new_di == 32'h0000_4000, "di kept on probe fault R8", new_di, 32'h4000);
    finish_pulse("probe fault pulse R9");
  endtask

  task automatic t_store_fault;
    bit got;
    prep(2, 2, 1);
    dir_ins = 1; byte_form = 1; addr32 = 1; dflag = 1;
    di_in = 32'h0000_5000; prot_en = 0; rd_io = 32'h11;
    run_op(got);
    chk(got && fault_kind == 2, "store fault kind R8", {30'b0, fault_kind}, 2);
    chk(n_io == 1 && n_mem == 2, "port read before store fault R8 R10", n_io, 1);
    chk(new_di == 32'h0000_5000, "di kept on store fault R8", new_di, 32'h5000);
    finish_pulse("store fault pulse R9");
  endtask

  initial begin
    int cyc;
    for (cyc = 0; cyc < 200000; cyc++) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_ins_byte_wrap();
    t_outs_dword_ovr();
    t_outs_word_ds();
    t_gp_deny();
    t_probe_fault();
    t_store_fault();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule